// File: doc/BRIEF.md
# Two-Counter Performance Monitor

This block counts hardware activity for profiling. It holds one cycle counter and two event counters, each 32 bits wide. Each event counter watches one line of a 256-wide vector of one-clock event pulses. An 8-bit code picks the line. Code 0xFF, and any code outside the defined set, parks the counter. The cycle counter counts clocks, either every clock or once every 64 clocks.

All settings live in a single packed control word. That word holds the run enable, the divide mode, two self-clearing counter-clear strobes, three interrupt enables, three sticky overflow flags and the two event selectors. The overflow flags are cleared by writing a 1 to them. A small register bus reaches the control word and the three counters. The level interrupt stays high while any enabled flag is set.

Software loads a counter with a start value and picks an event. It then sets the run bit. It takes the interrupt when a counter wraps from all ones to zero, reads the flags to find the source, and writes the flags back to clear them.

Top module: `perf_monitor`

## Requirements
- R1: After a synchronous reset all three counters read 0. The control word reads 0x0FFFF000: both selectors hold 0xFF and every other field is 0. The interrupt output is low.
- R2: Control layout: bit 0 run, bit 1 event-counter clear strobe, bit 2 cycle-counter clear strobe, bit 3 divide mode, bits 6:4 interrupt enables (event 0, event 1, cycle), bits 10:8 overflow flags (same order), bits 19:12 event-0 code, bits 27:20 event-1 code. Bits 1, 2, 7, 11 and 31:28 always read 0, so writing all ones reads back 0x0FFFF079.
- R3: While run is 1, an event counter advances by one on each clock where the pulse line named by its code is high and the code is defined. Defined codes are 0x00–0x0D, 0x10–0x12 and 0x14–0x16. Nothing counts while run is 0.
- R4: An event counter whose code is 0xFF, or any undefined code (for example 0x0E, 0x13, 0x17), holds its value whatever the pulses do.
- R5: With divide mode off and run on, the cycle counter advances by one every clock.
- R6: With divide mode on, the cycle counter advances once per 64 running clocks. It first advances on the 64th running clock after a cycle-clear strobe.
- R7: When a counter advances from 0xFFFFFFFF it becomes 0 and sets its overflow flag.
- R8: Writing 1 to a flag bit clears that flag, and writing 0 leaves it. If an overflow occurs in the same clock as the clear, the flag stays set.
- R9: The interrupt output is high exactly while some flag and its matching enable are both set. It changes in the clock after the flag or enable register changes.
- R10: Strobe bits 1 and 2 zero the event counters and the cycle counter in the clock they are written. The zeroing wins over a count in that clock.
- R11: A bus write to a counter loads the written value and wins over a count in the same clock. A load never sets a flag.
- R12: The bus address selects the register: 0 control, 1 cycle counter, 2 event counter 0, 3 event counter 1. The read data is registered. It shows, one clock after the address is presented, the register's value from before that clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ev_pulse | input | 256 | One-clock event pulses, indexed by event code |
| bus_we | input | 1 | Write strobe for the addressed register |
| bus_addr | input | 2 | Register address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data for the address of the previous clock |
| irq | output | 1 | Level interrupt: some enabled overflow flag is set |

## Verification
A wrong counter value shows on the next read of that counter, one clock after its address is presented. A counter that misses or gains a count shows up the same way. A flag that is set, cleared or lost at the wrong time shows on the interrupt line in the following clock when its enable is on. It also shows in bits 10:8 of the next control read. The bench follows every clock with an independent model and compares both outputs each cycle. Any divergence is therefore caught within one clock of the address or interrupt enable that exposes it.

// File: rtl/pmu_pkg.sv
package pmu_pkg;
  localparam int DW        = 32;   // bus and control word width
  localparam int SEL_W     = 8;    // event code width
  localparam int NUM_CODES = 1 << SEL_W;
  localparam int NEV_CTR   = 2;    // event counters
  localparam int NCTR      = NEV_CTR + 1;
  localparam int CYC_IDX   = NEV_CTR; // cycle counter sits after the event counters

  // control word bit positions (decoded by software)
  localparam int CB_RUN   = 0;
  localparam int CB_EVCLR = 1;
  localparam int CB_CYCLR = 2;
  localparam int CB_DIV   = 3;
  localparam int CB_IEN   = 4;
  localparam int CB_FLG   = 8;
  localparam int CB_SEL   = 12;

  localparam logic [SEL_W-1:0] CODE_IDLE = '1;

  typedef enum logic [1:0] {
    A_CTRL = 2'd0,
    A_CYC  = 2'd1,
    A_EV0  = 2'd2,
    A_EV1  = 2'd3
  } reg_addr_e;

  function automatic logic code_live(input logic [SEL_W-1:0] c);
    return (c <= 8'h0D) || (c >= 8'h10 && c <= 8'h12) || (c >= 8'h14 && c <= 8'h16);
  endfunction
endpackage

// File: rtl/pmu_counter.sv
module pmu_counter #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         ld,
  input  logic [W-1:0] ld_val,
  input  logic         clr,
  input  logic         inc,
  output logic [W-1:0] cnt,
  output logic         ovf
);
  // a wrap only counts when neither load nor clear overrides the step
  assign ovf = inc && !ld && !clr && (&cnt);

  always_ff @(posedge clk) begin
    if (rst)       cnt <= '0;
    else if (ld)   cnt <= ld_val;
    else if (clr)  cnt <= '0;
    else if (inc)  cnt <= cnt + 1'b1;
  end

  // R11
  load_win_chk: assert property (@(posedge clk) disable iff (rst)
    ld |=> cnt == $past(ld_val));
  // R10
  clear_win_chk: assert property (@(posedge clk) disable iff (rst)
    (clr && !ld) |=> cnt == '0);
  // R4
  hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!inc && !ld && !clr) |=> $stable(cnt));
  // R7
  wrap_zero_chk: assert property (@(posedge clk) disable iff (rst)
    ovf |=> cnt == '0);
endmodule

// File: rtl/pmu_prescaler.sv
module pmu_prescaler #(
  parameter int LOG2 = 6
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  input  logic clr,
  input  logic div_en,
  output logic tick
);
  logic [LOG2-1:0] pre;

  assign tick = run && (!div_en || (&pre));

  always_ff @(posedge clk) begin
    if (rst || clr) pre <= '0;
    else if (run)   pre <= pre + 1'b1;
  end

  // R6
  div_wrap_chk: assert property (@(posedge clk) disable iff (rst)
    (run && div_en && tick && !clr) |=> pre == '0);
  // R6
  idle_tick_chk: assert property (@(posedge clk) disable iff (rst)
    !run |-> !tick);
endmodule

// File: rtl/pmu_ctrl.sv
module pmu_ctrl import pmu_pkg::*; (
  input  logic                            clk,
  input  logic                            rst,
  input  logic                            wr,
  input  logic [DW-1:0]                   wdata,
  input  logic [NCTR-1:0]                 ovf,
  output logic                            run,
  output logic                            div_mode,
  output logic                            clr_ev,
  output logic                            clr_cyc,
  output logic [NEV_CTR-1:0][SEL_W-1:0]   sel,
  output logic [DW-1:0]                   word,
  output logic                            irq
);
  logic [NCTR-1:0] ien;
  logic [NCTR-1:0] flags;
  logic [NCTR-1:0] w1c;
  logic            unused_bits;

  // strobes act in the write cycle and are never stored
  assign clr_ev  = wr && wdata[CB_EVCLR];
  assign clr_cyc = wr && wdata[CB_CYCLR];
  assign w1c     = wr ? wdata[CB_FLG +: NCTR] : '0;
  assign unused_bits = ^{wdata[31:28], wdata[11], wdata[7]};

  always_ff @(posedge clk) begin
    if (rst) begin
      run      <= 1'b0;
      div_mode <= 1'b0;
      ien      <= '0;
      flags    <= '0;
      for (int i = 0; i < NEV_CTR; i++) sel[i] <= CODE_IDLE;
    end else begin
      if (wr) begin
        run      <= wdata[CB_RUN];
        div_mode <= wdata[CB_DIV];
        ien      <= wdata[CB_IEN +: NCTR];
        for (int i = 0; i < NEV_CTR; i++) sel[i] <= wdata[CB_SEL + i*SEL_W +: SEL_W];
      end
      flags <= (flags & ~w1c) | ovf;
    end
  end

  always_comb begin
    word = '0;
    word[CB_RUN]            = run;
    word[CB_DIV]            = div_mode;
    word[CB_IEN +: NCTR]    = ien;
    word[CB_FLG +: NCTR]    = flags;
    for (int i = 0; i < NEV_CTR; i++) word[CB_SEL + i*SEL_W +: SEL_W] = sel[i];
  end

  assign irq = |(flags & ien);

  // R7
  flag_set_chk: assert property (@(posedge clk) disable iff (rst)
    (ovf != '0) |=> ((flags & $past(ovf)) == $past(ovf)));
  // R8
  flag_w1c_chk: assert property (@(posedge clk) disable iff (rst)
    (wr && wdata[CB_FLG] && !ovf[0]) |=> !flags[0]);
  // R8
  flag_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    (flags[CYC_IDX] && !(wr && wdata[CB_FLG + CYC_IDX])) |=> flags[CYC_IDX]);
  // R9
  irq_mask_chk: assert property (@(posedge clk) disable iff (rst)
    (ien == '0) |-> !irq);
endmodule

// File: rtl/perf_monitor.sv
module perf_monitor import pmu_pkg::*; #(
  parameter int CNT_W    = 32,
  parameter int DIV_LOG2 = 6
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [NUM_CODES-1:0] ev_pulse,
  input  logic                 bus_we,
  input  logic [1:0]           bus_addr,
  input  logic [DW-1:0]        bus_wdata,
  output logic [DW-1:0]        bus_rdata,
  output logic                 irq
);
  logic                          wr_ctrl;
  logic                          run, div_mode, clr_ev, clr_cyc, cyc_tick;
  logic [NEV_CTR-1:0][SEL_W-1:0] sel;
  logic [DW-1:0]                 ctrl_word;
  logic [NCTR-1:0][CNT_W-1:0]    cnt;
  logic [NCTR-1:0]               ovf;
  logic                          rd_ctrl_q;

  assign wr_ctrl = bus_we && (bus_addr == A_CTRL);

  pmu_ctrl u_ctrl (
    .clk(clk), .rst(rst), .wr(wr_ctrl), .wdata(bus_wdata), .ovf(ovf),
    .run(run), .div_mode(div_mode), .clr_ev(clr_ev), .clr_cyc(clr_cyc),
    .sel(sel), .word(ctrl_word), .irq(irq)
  );

  for (genvar g = 0; g < NEV_CTR; g++) begin : g_ev
    logic hit;
    logic ld;
    assign hit = run && ev_pulse[sel[g]] && code_live(sel[g]);
    assign ld  = bus_we && (bus_addr == 2'(A_EV0 + g));
    pmu_counter #(.W(CNT_W)) u_cnt (
      .clk(clk), .rst(rst), .ld(ld), .ld_val(bus_wdata[CNT_W-1:0]),
      .clr(clr_ev), .inc(hit), .cnt(cnt[g]), .ovf(ovf[g])
    );
  end

  pmu_prescaler #(.LOG2(DIV_LOG2)) u_pre (
    .clk(clk), .rst(rst), .run(run), .clr(clr_cyc), .div_en(div_mode), .tick(cyc_tick)
  );

  pmu_counter #(.W(CNT_W)) u_cyc (
    .clk(clk), .rst(rst), .ld(bus_we && (bus_addr == A_CYC)),
    .ld_val(bus_wdata[CNT_W-1:0]), .clr(clr_cyc), .inc(cyc_tick),
    .cnt(cnt[CYC_IDX]), .ovf(ovf[CYC_IDX])
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata <= '0;
      rd_ctrl_q <= 1'b0;
    end else begin
      rd_ctrl_q <= (bus_addr == A_CTRL);
      unique case (bus_addr)
        A_CTRL:  bus_rdata <= ctrl_word;
        A_CYC:   bus_rdata <= DW'(cnt[CYC_IDX]);
        A_EV0:   bus_rdata <= DW'(cnt[0]);
        default: bus_rdata <= DW'(cnt[1]);
      endcase
    end
  end

  // R2
  rsvd_zero_chk: assert property (@(posedge clk) disable iff (rst)
    rd_ctrl_q |-> (bus_rdata[31:28] == 4'h0 && !bus_rdata[11] && !bus_rdata[7] && bus_rdata[2:1] == 2'b00));
  // R12
  rd_cyc_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_addr == A_CYC) |=> bus_rdata == DW'($past(cnt[CYC_IDX])));
endmodule

// File: tb/test_perf_monitor.sv
module test_perf_monitor;
  logic         clk = 1'b0;
  logic         rst;
  logic [255:0] ev_pulse;
  logic         bus_we;
  logic [1:0]   bus_addr;
  logic [31:0]  bus_wdata;
  logic [31:0]  bus_rdata;
  logic         irq;

  always #5 clk = ~clk;

  perf_monitor i_perf_monitor (
    .clk(clk), .rst(rst), .ev_pulse(ev_pulse), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
  );

  int    total = 0;
  int    bad   = 0;
  int    ncyc  = 0;
  string tag   = "R1";

  // behavioural reference state
  bit        m_run, m_div;
  bit [2:0]  m_ien, m_flg;
  bit [7:0]  m_sel0, m_sel1;
  bit [31:0] m_ev0, m_ev1, m_cyc;
  int        m_pre;
  bit [31:0] m_rd;

  function automatic bit defined_code(input bit [7:0] c);
    if (c inside {[8'h00:8'h0D], [8'h10:8'h12], [8'h14:8'h16]}) return 1'b1;
    return 1'b0;
  endfunction

  function automatic bit [31:0] m_read(input bit [1:0] a);
    case (a)
      2'd0: return {4'h0, m_sel1, m_sel0, 1'b0, m_flg, 1'b0, m_ien, m_div, 2'b00, m_run};
      2'd1: return m_cyc;
      2'd2: return m_ev0;
      default: return m_ev1;
    endcase
  endfunction

  always @(posedge clk) begin
    bit [2:0] setf;
    bit       wc;
    m_rd = rst ? 32'h0 : m_read(bus_addr);
    if (rst) begin
      m_run = 0; m_div = 0; m_ien = 0; m_flg = 0; m_sel0 = 8'hFF; m_sel1 = 8'hFF;
      m_ev0 = 0; m_ev1 = 0; m_cyc = 0; m_pre = 0;
    end else begin
      setf = 0;
      wc = bus_we && bus_addr == 2'd0;
      // event counter 0
      if (bus_we && bus_addr == 2'd2) m_ev0 = bus_wdata;
      else if (wc && bus_wdata[1]) m_ev0 = 0;
      else if (m_run && ev_pulse[m_sel0] && defined_code(m_sel0)) begin
        if (m_ev0 == 32'hFFFF_FFFF) setf[0] = 1;
        m_ev0 = m_ev0 + 1;
      end
      // event counter 1
      if (bus_we && bus_addr == 2'd3) m_ev1 = bus_wdata;
      else if (wc && bus_wdata[1]) m_ev1 = 0;
      else if (m_run && ev_pulse[m_sel1] && defined_code(m_sel1)) begin
        if (m_ev1 == 32'hFFFF_FFFF) setf[1] = 1;
        m_ev1 = m_ev1 + 1;
      end
      // cycle counter
      if (bus_we && bus_addr == 2'd1) m_cyc = bus_wdata;
      else if (wc && bus_wdata[2]) m_cyc = 0;
      else if (m_run && (!m_div || m_pre == 63)) begin
        if (m_cyc == 32'hFFFF_FFFF) setf[2] = 1;
        m_cyc = m_cyc + 1;
      end
      if (wc && bus_wdata[2]) m_pre = 0;
      else if (m_run) m_pre = (m_pre + 1) % 64;
      if (wc) m_flg = m_flg & ~bus_wdata[10:8];
      m_flg = m_flg | setf;
      if (wc) begin
        m_run = bus_wdata[0]; m_div = bus_wdata[3]; m_ien = bus_wdata[6:4];
        m_sel0 = bus_wdata[19:12]; m_sel1 = bus_wdata[27:20];
      end
    end
  end

  task automatic chk(input string t, input bit [31:0] act, input bit [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", t, act, exp);
    end
  endtask

  // one clock: drive, wait for edge, compare both outputs against the model
  task automatic step(input bit we, input bit [1:0] a, input bit [31:0] d, input bit [255:0] ev);
    bus_we = we; bus_addr = a; bus_wdata = d; ev_pulse = ev;
    @(posedge clk);
    #2;
    chk({tag, " rdata"}, bus_rdata, m_rd);
    chk({tag, " irq"}, {31'h0, irq}, {31'h0, |(m_flg & m_ien)});
    bus_we = 0; ev_pulse = '0;
  endtask

  function automatic bit [31:0] cw(input bit run, input bit div, input bit [2:0] ien,
                                   input bit [7:0] s0, input bit [7:0] s1,
                                   input bit [1:0] strb, input bit [2:0] clrf);
    return {4'h0, s1, s0, 1'b0, clrf, 1'b0, ien, div, strb, run};
  endfunction

  function automatic bit [255:0] one_ev(input int code);
    bit [255:0] v = '0;
    v[code] = 1'b1;
    return v;
  endfunction

  function automatic bit [255:0] rnd_ev();
    return {$urandom, $urandom, $urandom, $urandom, $urandom, $urandom, $urandom, $urandom};
  endfunction

  initial begin
    rst = 1; bus_we = 0; bus_addr = 0; bus_wdata = 0; ev_pulse = '0;
    repeat (4) @(posedge clk);
    #2;
    rst = 0;

    // R1 reset state
    tag = "R1";
    step(0, 0, 0, '0); chk("R1 ctrl after reset", bus_rdata, 32'h0FFF_F000);
    step(0, 1, 0, '0); chk("R1 cycle after reset", bus_rdata, 0);
    step(0, 2, 0, '0); chk("R1 ev0 after reset", bus_rdata, 0);
    step(0, 3, 0, '0); chk("R1 ev1 after reset", bus_rdata, 0);
    chk("R1 irq after reset", {31'h0, irq}, 0);

    // R3 counting defined events, directed counts
    tag = "R3";
    step(1, 0, cw(1, 0, 0, 8'h07, 8'h16, 2'b01, 0), '0);
    for (int i = 0; i < 5; i++) step(0, 2, 0, one_ev(7));
    for (int i = 0; i < 3; i++) step(0, 2, 0, one_ev(8'h16));
    step(0, 2, 0, '0); chk("R3 ev0 five pulses", bus_rdata, 5);
    step(0, 3, 0, '0); chk("R3 ev1 three pulses", bus_rdata, 3);
    step(1, 0, cw(0, 0, 0, 8'h07, 8'h16, 0, 0), '0);
    for (int i = 0; i < 6; i++) step(0, 2, 0, one_ev(7));
    step(0, 2, 0, '0); chk("R3 no count while stopped", bus_rdata, 5);
    step(1, 0, cw(1, 0, 0, 8'h05, 8'h0A, 0, 0), '0);
    for (int i = 0; i < 120; i++) step(0, 2'($urandom), 0, rnd_ev());

    // R4 idle and undefined codes
    tag = "R4";
    step(1, 0, cw(1, 0, 0, 8'hFF, 8'h0E, 2'b01, 0), '1);
    for (int i = 0; i < 40; i++) step(0, 2'($urandom), 0, '1);
    step(0, 2, 0, '0); chk("R4 code FF holds", bus_rdata, 0);
    step(0, 3, 0, '0); chk("R4 code 0E holds", bus_rdata, 0);
    step(1, 0, cw(1, 0, 0, 8'h13, 8'h17, 0, 0), '0);
    for (int i = 0; i < 40; i++) step(0, 2'($urandom), 0, '1);
    step(0, 2, 0, '0); chk("R4 code 13 holds", bus_rdata, 0);
    step(0, 3, 0, '0); chk("R4 code 17 holds", bus_rdata, 0);

    // R5 cycle counter every clock
    tag = "R5";
    step(1, 0, cw(1, 0, 0, 8'hFF, 8'hFF, 2'b10, 0), '0);
    for (int i = 0; i < 10; i++) step(0, 1, 0, '0);
    chk("R5 cycle after ten clocks", bus_rdata, 9);

    // R6 divide by 64
    tag = "R6";
    step(1, 0, cw(1, 1, 0, 8'hFF, 8'hFF, 2'b10, 0), '0);
    for (int i = 0; i < 130; i++) step(0, 1, 0, '0);
    chk("R6 divided cycle count", bus_rdata, 2);

    // R7 / R9 event wrap with interrupt enabled
    tag = "R7";
    step(1, 0, cw(1, 0, 3'b001, 8'h05, 8'hFF, 0, 0), '0);
    step(1, 2, 32'hFFFF_FFFE, '0);
    step(0, 2, 0, one_ev(5));
    chk("R9 irq low before wrap", {31'h0, irq}, 0);
    step(0, 2, 0, one_ev(5));
    chk("R9 irq high after wrap", {31'h0, irq}, 1);
    step(0, 2, 0, '0); chk("R7 ev0 wrapped to zero", bus_rdata, 0);
    step(0, 0, 0, '0); chk("R7 ev0 flag set", bus_rdata & 32'h700, 32'h100);
    step(1, 1, 32'hFFFF_FFFD, '0);
    for (int i = 0; i < 5; i++) step(0, 0, 0, '0);
    chk("R7 cycle flag set", bus_rdata & 32'h700, 32'h500);
    chk("R9 cycle flag masked", {31'h0, irq}, 1);

    // R8 write-one-to-clear
    tag = "R8";
    step(1, 0, cw(1, 0, 3'b101, 8'h05, 8'hFF, 0, 3'b001), '0);
    step(0, 0, 0, '0); chk("R8 ev0 flag cleared", bus_rdata & 32'h700, 32'h400);
    chk("R9 irq follows cycle flag", {31'h0, irq}, 1);
    step(1, 0, cw(1, 0, 3'b101, 8'h05, 8'hFF, 0, 3'b000), '0);
    step(0, 0, 0, '0); chk("R8 zero leaves flag", bus_rdata & 32'h700, 32'h400);
    step(1, 0, cw(1, 0, 3'b001, 8'h05, 8'hFF, 0, 3'b100), '0);
    chk("R9 irq low after clear", {31'h0, irq}, 0);
    step(1, 2, 32'hFFFF_FFFF, '0);
    step(1, 0, cw(1, 0, 3'b001, 8'h05, 8'hFF, 0, 3'b001), one_ev(5));
    step(0, 0, 0, '0); chk("R8 set wins over clear", bus_rdata & 32'h100, 32'h100);

    // R10 clear strobes beat counting
    tag = "R10";
    step(1, 0, cw(1, 0, 0, 8'h02, 8'h03, 0, 3'b111), '0);
    for (int i = 0; i < 4; i++) step(0, 3, 0, '1);
    step(1, 0, cw(1, 0, 0, 8'h02, 8'h03, 2'b01, 0), '1);
    step(0, 2, 0, '0); chk("R10 ev0 zeroed", bus_rdata, 0);
    step(0, 3, 0, '0); chk("R10 ev1 zeroed", bus_rdata, 0);
    step(1, 0, cw(1, 0, 0, 8'h02, 8'h03, 2'b10, 0), '0);
    step(0, 1, 0, '0); chk("R10 cycle zeroed", bus_rdata, 0);

    // R11 load beats count
    tag = "R11";
    step(1, 2, 32'h0000_1234, one_ev(2));
    step(0, 2, 0, '0); chk("R11 load wins", bus_rdata, 32'h1234);
    step(1, 3, 32'hFFFF_FFFF, one_ev(3));
    step(0, 0, 0, '0); chk("R11 load sets no flag", bus_rdata & 32'h700, 0);

    // R2 reserved bits and strobes read zero
    tag = "R2";
    step(1, 0, 32'hFFFF_FFFF, '0);
    step(0, 0, 0, '0); chk("R2 all-ones readback", bus_rdata, 32'h0FFF_F079);

    // R12 random traffic, model compared every clock
    tag = "R12";
    for (int i = 0; i < 400; i++) begin
      bit we = ($urandom % 6) == 0;
      step(we, 2'($urandom), (($urandom % 3) == 0) ? 32'hFFFF_FFF0 | 32'($urandom % 16) : $urandom, rnd_ev());
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  always @(posedge clk) begin
    ncyc++;
    if (ncyc > 150000) begin
      total++; bad++;
      $display("FAIL watchdog expired actual=%0d expected<150000", ncyc);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule